// File: doc/BRIEF.md
# Half-Rate Linear-Phase FIR Decimator

This block low-pass filters a stream of signed 12-bit samples with a 40-tap linear-phase FIR and keeps every second result. Samples arrive at most one per clock under a valid strobe, and gaps between samples are allowed. The block produces one full-precision 36-bit result for each pair of accepted samples.

The input stage runs at the full clock rate. It steers the accepted samples alternately into an even-index delay line and an odd-index delay line, so each line holds one polyphase branch. Because the coefficients mirror about the centre, every even-indexed tap of the odd-sample branch has an equal partner among the odd-indexed taps of the even-sample branch. The block adds each such pair of samples before a single multiply, so it needs 20 multipliers instead of 40. The arithmetic after the delay lines sees new data at most once every two clocks. Only the 20 distinct coefficient values are supplied, as a parameter array.

Top module: `dec2_symfir`

## Requirements
- R1: A synchronous active-high reset clears both delay lines, the pair phase, the held even sample and the output. During reset and on the first cycle after it, out_valid is 0 and out_data is 0.
- R2: With accepted samples numbered x[0], x[1], ... from the first sample after reset, result m equals the sum over k = 0..39 of h[k]·x[2m+1−k]. Samples with a negative index count as zero.
- R3: Entry i of the coefficient array gives both tap h[2i] and tap h[39−2i], so h[k] = h[39−k] for every k. An impulse of amplitude A at an even index, followed by zeros, yields A·h[1], A·h[3], ... on successive outputs. An impulse at an odd index yields A·h[0], A·h[2], ....
- R4: out_valid pulses exactly once for every two accepted samples. Each pulse answers the second sample of a pair (x[1], x[3], ...), and no pulse occurs without such a sample.
- R5: If the second sample of a pair is presented in clock cycle t, out_valid is high, with its result on out_data, in cycle t+4.
- R6: A cycle with in_valid low changes no state, whatever in_data carries. The samples that are accepted give results as if they had arrived back to back.
- R7: out_data is the exact 36-bit two's-complement sum, with no rounding, truncation or wrap. This holds even with full-scale inputs of −2048 or 2047 and coefficients of −131072 or 131071.
- R8: out_valid is never high on two consecutive cycles, and out_data keeps the last result until the next pulse.
- R9: A reset asserted in the middle of a stream drops a pending half pair and any results still in the pipeline. The first sample after release becomes x[0] of a new pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per cycle at most |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_data carries a sample this cycle |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 36 | Signed full-precision filtered result |

## Verification
Two things can happen in the same cycle: a new sample is accepted into the delay lines while the pre-add, multiply and sum stages are still working on the previous pair. In particular, the first sample of the next pair arrives exactly as the pre-add registers capture the lines. The bench provokes this with long streams of back-to-back samples and with gapped streams of random density. It judges every strobe against an arithmetic model of the 40-tap sum: the model checks the value and the exact strobe cycle, and the bench also checks that out_data holds between strobes.

// File: rtl/dec2_symfir_pkg.sv
package dec2_symfir_pkg;

  localparam int DEF_DW   = 12;
  localparam int DEF_CW   = 18;
  localparam int DEF_TAPS = 40;

  // one bit for the symmetric pre-add, log2 of the product count for the sum
  function automatic int pre_width(input int dw);
    return dw + 1;
  endfunction

  function automatic int prod_width(input int dw, input int cw);
    return dw + 1 + cw;
  endfunction

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + 1 + cw + $clog2(taps / 2);
  endfunction

endpackage

// File: rtl/dec2_symfir_split.sv
// Full-rate input stage: alternates accepted samples between two polyphase
// delay lines and flags each completed pair.
module dec2_symfir_split #(
  parameter int DW   = 12,
  parameter int HALF = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic signed [DW-1:0] odd_line  [HALF],
  output logic signed [DW-1:0] even_line [HALF],
  output logic                 fire
);

  logic                 phase;      // 1: next sample closes a pair
  logic signed [DW-1:0] even_hold;
  logic                 shift_en;

  assign shift_en = in_valid && phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      even_hold <= '0;
      fire      <= 1'b0;
    end else begin
      fire <= shift_en;
      if (in_valid) begin
        phase <= ~phase;
        if (!phase) even_hold <= in_data;
      end
    end
  end

  // head of each line takes the new pair
  always_ff @(posedge clk) begin
    if (rst) begin
      odd_line[0]  <= '0;
      even_line[0] <= '0;
    end else if (shift_en) begin
      odd_line[0]  <= in_data;
      even_line[0] <= even_hold;
    end
  end

  for (genvar i = 1; i < HALF; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) begin
        odd_line[i]  <= '0;
        even_line[i] <= '0;
      end else if (shift_en) begin
        odd_line[i]  <= odd_line[i-1];
        even_line[i] <= even_line[i-1];
      end
    end
  end

  p_pair_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase) |=> fire);

  p_no_fire_r4: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && phase) |=> !fire);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(phase) && $stable(even_hold) && $stable(odd_line[0])));

endmodule

// File: rtl/dec2_symfir_mac.sv
// Half-rate arithmetic: symmetric pre-add across the two branches, then one
// multiply per distinct coefficient.
module dec2_symfir_mac
  import dec2_symfir_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 18,
  parameter int HALF = 20,
  parameter logic signed [CW-1:0] COEFS [HALF] = '{default: '0},
  localparam int SW = pre_width(DW),
  localparam int PW = prod_width(DW, CW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic signed [DW-1:0] odd_line  [HALF],
  input  logic signed [DW-1:0] even_line [HALF],
  output logic signed [PW-1:0] prod      [HALF],
  output logic                 prod_valid
);

  logic pre_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_valid  <= 1'b0;
      prod_valid <= 1'b0;
    end else begin
      pre_valid  <= fire;
      prod_valid <= pre_valid;
    end
  end

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    localparam logic signed [CW-1:0] C = COEFS[i];
    logic signed [SW-1:0] pre_q;

    // odd-branch tap 2i pairs with even-branch tap (2*HALF-1-2i)
    always_ff @(posedge clk) begin
      if (rst) begin
        pre_q <= '0;
      end else if (fire) begin
        pre_q <= SW'(odd_line[i]) + SW'(even_line[HALF-1-i]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prod[i] <= '0;
      end else if (pre_valid) begin
        prod[i] <= PW'(pre_q) * PW'(C);
      end
    end
  end

  // delay lines must stay put while the pre-adders capture them
  p_lines_settled_r4: assert property (@(posedge clk) disable iff (rst)
    fire |=> ($stable(odd_line[0]) && $stable(even_line[0])));

endmodule

// File: rtl/dec2_symfir_sum.sv
// Full-precision reduction of the products and the registered output.
module dec2_symfir_sum #(
  parameter int PW   = 31,
  parameter int HALF = 20,
  parameter int AW   = 36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [PW-1:0] prod [HALF],
  input  logic                 prod_valid,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);

  logic signed [AW-1:0] total;
  logic                 rst_d;

  always_comb begin
    total = '0;
    for (int i = 0; i < HALF; i++) begin
      total = total + AW'(prod[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= prod_valid;
      if (prod_valid) out_data <= total;
    end
  end

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d) begin
      p_reset_clear_r1: assert (!out_valid && out_data == '0);
    end
  end

endmodule

// File: rtl/dec2_symfir.sv
module dec2_symfir
  import dec2_symfir_pkg::*;
#(
  parameter int DW   = DEF_DW,
  parameter int CW   = DEF_CW,
  parameter int TAPS = DEF_TAPS,
  parameter logic signed [CW-1:0] COEFS [TAPS/2] = '{
    -412, -1093, 1204, 3310, -2271, -7815, 3620, 15220, -5102, -26883,
    6409, 45120, -7311, -74410, 7689, 131071, -131072, 98304, 65536, 120000},
  localparam int HALF = TAPS / 2,
  localparam int PW   = prod_width(DW, CW),
  localparam int AW   = acc_width(DW, CW, TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);

  logic signed [DW-1:0] odd_line  [HALF];
  logic signed [DW-1:0] even_line [HALF];
  logic                 fire;
  logic signed [PW-1:0] prod      [HALF];
  logic                 prod_valid;

  dec2_symfir_split #(.DW(DW), .HALF(HALF)) split_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .odd_line  (odd_line),
    .even_line (even_line),
    .fire      (fire)
  );

  dec2_symfir_mac #(.DW(DW), .CW(CW), .HALF(HALF), .COEFS(COEFS)) mac_i (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .odd_line   (odd_line),
    .even_line  (even_line),
    .prod       (prod),
    .prod_valid (prod_valid)
  );

  dec2_symfir_sum #(.PW(PW), .HALF(HALF), .AW(AW)) sum_i (
    .clk        (clk),
    .rst        (rst),
    .prod       (prod),
    .prod_valid (prod_valid),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  p_strobe_gap_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

endmodule

// File: tb/dec2_symfir_tb_top.sv
`timescale 1ns/1ps
module dec2_symfir_tb_top;

  localparam int DW   = 12;
  localparam int CW   = 18;
  localparam int TAPS = 40;
  localparam int HALF = TAPS / 2;
  localparam int AW   = 36;
  localparam logic signed [CW-1:0] TB_COEFS [HALF] = '{
    131071, -131072, 5, -7, 1000, -2000, 3, 77777, -131072, 12345,
    -1, 0, 40000, -40000, 2, 131071, -99999, 600, -131072, 17};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic signed [AW-1:0] out_data;

  dec2_symfir #(.DW(DW), .CW(CW), .TAPS(TAPS), .COEFS(TB_COEFS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          vectors = 0;
  int          errors  = 0;
  string       req     = "R2";
  longint      hist[$];
  longint      exp_val[$];
  int unsigned exp_cyc[$];
  longint      last_data = 0;
  logic        last_valid = 1'b0;
  bit          done = 1'b0;

  function automatic longint tap(input int k);
    if (k % 2 == 0) return longint'(TB_COEFS[k/2]);
    return longint'(TB_COEFS[(TAPS-1-k)/2]);   // mirror tap (R3)
  endfunction

  function automatic longint model();
    longint acc;
    int     n;
    acc = 0;
    n   = hist.size() - 1;
    for (int k = 0; k < TAPS; k++) begin
      if (n - k >= 0) acc += tap(k) * hist[n-k];
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string r, input string what,
                       input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        check(!last_valid, "R8", "strobe on consecutive cycles", 1, 0);
        if (exp_val.size() == 0) begin
          check(1'b0, "R4", "strobe without a completed pair", 1, 0);
        end else begin
          longint      e;
          int unsigned c;
          e = exp_val.pop_front();
          c = exp_cyc.pop_front();
          check(out_data == e, req, "result value", out_data, e);
          check(cyc == c, "R5", "strobe cycle", cyc, c);
        end
        last_data = out_data;
      end else begin
        check(out_data == last_data, "R8", "hold between strobes", out_data, last_data);
      end
      last_valid = out_valid;
    end else begin
      last_valid = 1'b0;
      last_data  = 0;
    end
  end

  task automatic push(input bit v, input logic signed [DW-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v) begin
      hist.push_back(longint'(d));
      if (hist.size() % 2 == 0) begin
        exp_val.push_back(model());
        exp_cyc.push_back(cyc + 4);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push(1'b0, DW'($urandom));
  endtask

  task automatic do_reset();
    idle(8);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_data = DW'($urandom);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    hist.delete();
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_data == '0, "R1", "out_data after reset", out_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_data == '0, "R1", "out_data after reset", out_data, 0);

    // R3: impulses at both phases recover every tap
    req = "R3";
    push(1'b1, 12'sd1000);
    for (int i = 0; i < 45; i++) push(1'b1, '0);
    do_reset();
    push(1'b1, '0);
    push(1'b1, -12'sd777);
    for (int i = 0; i < 44; i++) push(1'b1, '0);
    idle(8);

    // R2: dense random stream, new pairs overlap pipeline work
    req = "R2";
    for (int i = 0; i < 200; i++) push(1'b1, DW'($urandom));
    idle(8);

    // R6: gapped stream with junk on idle cycles, then a long quiet spell
    req = "R6";
    for (int i = 0; i < 300; i++) push(($urandom % 3) == 0, DW'($urandom));
    idle(40);

    // R7: full-scale extremes
    req = "R7";
    for (int i = 0; i < 60; i++) push(1'b1, -12'sd2048);
    for (int i = 0; i < 60; i++) push(1'b1, 12'sd2047);
    for (int i = 0; i < 60; i++) push(1'b1, (i % 2 == 0) ? -12'sd2048 : 12'sd2047);
    for (int i = 0; i < 60; i++) push(1'b1, (tap(i % TAPS) < 0) ? -12'sd2048 : 12'sd2047);
    idle(8);

    // R9: reset with half a pair pending
    req = "R9";
    do_reset();
    for (int i = 0; i < 3; i++) push(1'b1, DW'($urandom));
    do_reset();
    for (int i = 0; i < 41; i++) push(1'b1, DW'($urandom));
    for (int i = 0; i < 40; i++) push(($urandom % 2) == 0, DW'($urandom));
    idle(10);

    check(exp_val.size() == 0, "R4", "results never strobed", exp_val.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule